// File: doc/BRIEF.md
# Dual-Clock FIFO Lane with Status Flags

This block is one direction of a bidirectional buffer: a 36-bit first-in first-out store of parameterized depth (512 words by default) that joins two unrelated clock domains. The port-A side loads words on its own clock. The port-B side removes them on a second clock. Each side qualifies an access with an enable, a request, a direction bit and a select code. Only an access that carries all four takes effect.

Writes into a full store and reads from an empty store are dropped without notice, and they leave both pointers where they were. The write side reports full and more-than-half-full. The read side reports empty. Full and empty rise on a rising edge of their own clock and fall on a falling edge. Half-full moves only on rising edges of the write clock.

The read word sits in an output register that keeps its value until the next accepted read. An active-low output enable forces the visible data to zero but does not block reads. The pointers cross between domains in Gray code through two-flop synchronizers.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: A write is accepted on a rising edge of `clk_a` only when `en_a`=1, `req_a`=1, `rnw_a`=0 and `sel_a` equals the select code 3'd4. If any one of these is missing, nothing is stored.
- R2: A qualified write while `full_a`=1 is ignored. The data is never read out, the pointers do not move and `full_a` stays high.
- R3: A read is accepted on a rising edge of `clk_b` only when `en_b`=1, `req_b`=1, `rnw_b`=1 and `sel_b`=1. The words come out in write order, and each one is visible on `dout_b` after the edge of its read.
- R4: A qualified read while `empty_b`=1 is ignored. `dout_b` keeps the last word that was read.
- R5: `full_a` rises while `clk_a` is high, at the rising edge of the write that fills the store. After a read has freed a location, `full_a` falls only while `clk_a` is low, at a falling edge.
- R6: `empty_b` rises while `clk_b` is high, at the rising edge of the read that takes the last word. After a write into the empty store, `empty_b` falls only while `clk_b` is low, at a falling edge.
- R7: `half_a` is 1 exactly when the occupancy is strictly greater than DEPTH/2 (once the flags have settled). It changes only while `clk_a` is high.
- R8: While `oe_b_n`=1, `dout_b` reads zero. A read made in that state still pops its word, and that word appears on `dout_b` once `oe_b_n` returns to 0.
- R9: A synchronous reset (`rst_a` with `rst_b`) empties the store, sets `empty_b`=1, clears `full_a` and `half_a`, and clears the output register, so `dout_b`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| rst_a | input | 1 | Synchronous active-high reset, write side |
| en_a | input | 1 | Write-side enable |
| req_a | input | 1 | Write-side request |
| rnw_a | input | 1 | Write-side direction, 0 = write |
| sel_a | input | 3 | Write-side select; 3'd4 addresses this store |
| din_a | input | 36 | Write data |
| full_a | output | 1 | Store full |
| half_a | output | 1 | Occupancy above half the depth |
| clk_b | input | 1 | Read-side clock |
| rst_b | input | 1 | Synchronous active-high reset, read side |
| en_b | input | 1 | Read-side enable |
| req_b | input | 1 | Read-side request |
| rnw_b | input | 1 | Read-side direction, 1 = read |
| sel_b | input | 1 | Read-side select; 1 addresses this store |
| oe_b_n | input | 1 | Active-low output enable for `dout_b` |
| dout_b | output | 36 | Registered read data, zero while disabled |
| empty_b | output | 1 | Store empty |

## Verification
Some flags react to the local pointer and some to the other domain.

- **Same-domain flags.** Full and half-full respond to a write at that very `clk_a` rising edge. Empty responds to a read at that very `clk_b` rising edge. Read data also shows at the edge of its read. The bench therefore samples each of these 1 ns after that edge.
- **Cross-domain changes.** A change coming from the other domain needs two to three edges of the observing clock. A release then lands on the next falling edge. So after each batch of operations the bench waits five edges of each clock before it compares the settled flags with a queue model of the occupancy.
- **Edge monitors.** Every rise and fall of full, empty and half-full is checked against the level of its clock at that instant. This proves the rising-edge set and falling-edge release without having to predict the synchronizer phase.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    localparam int unsigned PTR_MAX = 16;
    typedef logic [PTR_MAX-1:0] wide_ptr_t;

    typedef struct packed {
        logic en;
        logic req;
        logic rnw;
    } port_ctl_t;

    function automatic wide_ptr_t to_gray(wide_ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic wide_ptr_t from_gray(wide_ptr_t g);
        wide_ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic qualify(port_ctl_t c, logic want_read, logic sel_hit);
        return c.en & c.req & (c.rnw == want_read) & sel_hit;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_edge_flag.sv
`timescale 1ns/1ps
module dcf_edge_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_q,
    output logic flag
);
    logic hold_q;

    always_ff @(negedge clk) begin
        if (rst) hold_q <= RST_VAL;
        else     hold_q <= rise_q;
    end

    assign flag = rise_q | hold_q;
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
    parameter int unsigned DW = 36,
    parameter int unsigned AW = 9
) (
    input  logic          clk_w,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          clk_r,
    input  logic          rst_r,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata_q
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];

    always_ff @(posedge clk_w) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk_r) begin
        if (rst_r)   rdata_q <= '0;
        else if (re) rdata_q <= store[raddr];
    end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int unsigned AW = 9,
    parameter int unsigned SEL_W = 3,
    parameter logic [SEL_W-1:0] SEL_CODE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  port_ctl_t        ctl,
    input  logic [SEL_W-1:0] sel,
    input  logic [AW:0]      rgray_s,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [AW:0]      wgray,
    output logic             full_q,
    output logic             half_q
);
    localparam int unsigned PW = AW + 1;
    localparam logic [AW:0] HALF_PT = PW'(1 << (AW - 1));

    logic          wr_req;
    logic [AW:0]   wbin, wbin_nxt, wgray_nxt, full_pat, rbin_s, occ_nxt;

    always_comb begin
        wr_req    = qualify(ctl, 1'b0, sel == SEL_CODE);
        we        = wr_req & ~full_q;
        wbin_nxt  = wbin + {{AW{1'b0}}, we};
        wgray_nxt = PW'(to_gray(wide_ptr_t'(wbin_nxt)));
        full_pat  = {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};
        rbin_s    = PW'(from_gray(wide_ptr_t'(rgray_s)));
        occ_nxt   = wbin_nxt - rbin_s;
    end

    assign waddr = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            full_q <= 1'b0;
            half_q <= 1'b0;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= wgray_nxt;
            full_q <= (wgray_nxt == full_pat);
            half_q <= (occ_nxt > HALF_PT);
        end
    end

    // R2: a write while full leaves the write pointer alone
    a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full_q) |=> $stable(wbin));

    // R1: an accepted write advances the Gray pointer by a single bit
    a_r1_wr_gray_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wgray ^ $past(wgray)));

    // R7: a full store is always above half depth
    a_r7_full_implies_half: assert property (@(posedge clk) disable iff (rst)
        full_q |-> half_q);
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int unsigned AW = 9,
    parameter int unsigned SEL_W = 1,
    parameter logic [SEL_W-1:0] SEL_CODE = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  port_ctl_t        ctl,
    input  logic [SEL_W-1:0] sel,
    input  logic [AW:0]      wgray_s,
    output logic             re,
    output logic [AW-1:0]    raddr,
    output logic [AW:0]      rgray,
    output logic             empty_q
);
    localparam int unsigned PW = AW + 1;

    logic        rd_req;
    logic [AW:0] rbin, rbin_nxt, rgray_nxt;

    always_comb begin
        rd_req    = qualify(ctl, 1'b1, sel == SEL_CODE);
        re        = rd_req & ~empty_q;
        rbin_nxt  = rbin + {{AW{1'b0}}, re};
        rgray_nxt = PW'(to_gray(wide_ptr_t'(rbin_nxt)));
    end

    assign raddr = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_q <= 1'b1;
        end else begin
            rbin    <= rbin_nxt;
            rgray   <= rgray_nxt;
            empty_q <= (rgray_nxt == wgray_s);
        end
    end

    // R4: a read while empty leaves the read pointer alone
    a_r4_no_read_when_empty: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty_q) |=> $stable(rbin));

    // R3: an accepted read advances the Gray pointer by a single bit
    a_r3_rd_gray_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/dual_clk_flag_fifo.sv
`timescale 1ns/1ps
module dual_clk_flag_fifo
    import dcf_pkg::*;
#(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned DEPTH = 512,
    parameter int unsigned SEL_A_W = 3,
    parameter logic [SEL_A_W-1:0] SEL_A_CODE = 3'd4,
    parameter int unsigned SEL_B_W = 1,
    parameter logic [SEL_B_W-1:0] SEL_B_CODE = 1'b1
) (
    input  logic               clk_a,
    input  logic               rst_a,
    input  logic               en_a,
    input  logic               req_a,
    input  logic               rnw_a,
    input  logic [SEL_A_W-1:0] sel_a,
    input  logic [DATA_W-1:0]  din_a,
    output logic               full_a,
    output logic               half_a,
    input  logic               clk_b,
    input  logic               rst_b,
    input  logic               en_b,
    input  logic               req_b,
    input  logic               rnw_b,
    input  logic [SEL_B_W-1:0] sel_b,
    input  logic               oe_b_n,
    output logic [DATA_W-1:0]  dout_b,
    output logic               empty_b
);
    localparam int unsigned AW = $clog2(DEPTH);

    port_ctl_t      ctl_a, ctl_b;
    logic           we, re, full_q, empty_q;
    logic [AW-1:0]  waddr, raddr;
    logic [AW:0]    wgray, rgray, wgray_s, rgray_s;
    logic [DATA_W-1:0] rdata_q;

    assign ctl_a = '{en: en_a, req: req_a, rnw: rnw_a};
    assign ctl_b = '{en: en_b, req: req_b, rnw: rnw_b};

    dcf_wr_side #(.AW(AW), .SEL_W(SEL_A_W), .SEL_CODE(SEL_A_CODE)) u_wr (
        .clk(clk_a), .rst(rst_a), .ctl(ctl_a), .sel(sel_a), .rgray_s(rgray_s),
        .we(we), .waddr(waddr), .wgray(wgray), .full_q(full_q), .half_q(half_a)
    );

    dcf_rd_side #(.AW(AW), .SEL_W(SEL_B_W), .SEL_CODE(SEL_B_CODE)) u_rd (
        .clk(clk_b), .rst(rst_b), .ctl(ctl_b), .sel(sel_b), .wgray_s(wgray_s),
        .re(re), .raddr(raddr), .rgray(rgray), .empty_q(empty_q)
    );

    dcf_sync #(.W(AW + 1)) u_w2r (.clk(clk_b), .rst(rst_b), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(AW + 1)) u_r2w (.clk(clk_a), .rst(rst_a), .d(rgray), .q(rgray_s));

    dcf_mem #(.DW(DATA_W), .AW(AW)) u_mem (
        .clk_w(clk_a), .we(we), .waddr(waddr), .wdata(din_a),
        .clk_r(clk_b), .rst_r(rst_b), .re(re), .raddr(raddr), .rdata_q(rdata_q)
    );

    dcf_edge_flag #(.RST_VAL(1'b0)) u_full_flag (
        .clk(clk_a), .rst(rst_a), .rise_q(full_q), .flag(full_a)
    );
    dcf_edge_flag #(.RST_VAL(1'b1)) u_empty_flag (
        .clk(clk_b), .rst(rst_b), .rise_q(empty_q), .flag(empty_b)
    );

    assign dout_b = oe_b_n ? '0 : rdata_q;

    // R8: disabled outputs read zero
    a_r8_oe_gates_data: assert property (@(posedge clk_b) disable iff (rst_b)
        oe_b_n |-> (dout_b == '0));
endmodule

// File: tb/dual_clk_flag_fifo_tb.sv
`timescale 1ns/1ps
module dual_clk_flag_fifo_tb_top;
    localparam int DEPTH = 16;
    localparam int NV = 10;
    // each row: writes, reads, expected occupancy afterwards
    localparam int VEC [NV][3] = '{
        '{5, 0, 5}, '{4, 0, 9}, '{7, 0, 16}, '{3, 0, 16}, '{0, 3, 13},
        '{0, 13, 0}, '{0, 2, 0}, '{8, 0, 8}, '{1, 0, 9}, '{0, 9, 0}
    };

    logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
    logic en_a = 0, req_a = 0, rnw_a = 0, en_b = 0, req_b = 0, rnw_b = 0;
    logic [2:0] sel_a = 0;
    logic sel_b = 0, oe_b_n = 0;
    logic [35:0] din_a = 0;
    logic full_a, half_a, empty_b;
    logic [35:0] dout_b;

    int checks = 0, failures = 0, seq = 0;
    bit mon_on = 0;
    logic [35:0] model_q [$];
    logic [35:0] last_rd = '0;

    always #4 clk_a = ~clk_a;
    always #5.5 clk_b = ~clk_b;

    dual_clk_flag_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .req_a(req_a), .rnw_a(rnw_a),
        .sel_a(sel_a), .din_a(din_a), .full_a(full_a), .half_a(half_a),
        .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .req_b(req_b), .rnw_b(rnw_b),
        .sel_b(sel_b), .oe_b_n(oe_b_n), .dout_b(dout_b), .empty_b(empty_b)
    );

    task automatic check(bit ok, string req, string what, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // flag edge monitors
    always @(posedge full_a) if (mon_on) check(clk_a === 1'b1, "R5", "full rise clk level", clk_a, 1);
    always @(negedge full_a) if (mon_on) check(clk_a === 1'b0, "R5", "full release clk level", clk_a, 0);
    always @(posedge empty_b) if (mon_on) check(clk_b === 1'b1, "R6", "empty rise clk level", clk_b, 1);
    always @(negedge empty_b) if (mon_on) check(clk_b === 1'b0, "R6", "empty release clk level", clk_b, 0);
    always @(half_a) if (mon_on) check(clk_a === 1'b1, "R7", "half change clk level", clk_a, 1);

    function automatic logic [35:0] next_word();
        seq++;
        return {4'hC, 32'(seq * 32'h9E37 + 7)};
    endfunction

    task automatic port_a(bit en, bit req, bit rnw, logic [2:0] sel, logic [35:0] d);
        bit ok;
        @(negedge clk_a);
        en_a = en; req_a = req; rnw_a = rnw; sel_a = sel; din_a = d;
        ok = en && req && !rnw && sel == 3'd4 && model_q.size() < DEPTH;
        @(posedge clk_a); #1;
        en_a = 0; req_a = 0;
        if (ok) begin
            model_q.push_back(d);
            if (model_q.size() == DEPTH) check(full_a === 1'b1, "R5", "full at filling edge", full_a, 1);
        end else if (en && req && !rnw && sel == 3'd4) begin
            check(full_a === 1'b1, "R2", "full holds on locked write", full_a, 1);
        end
    endtask

    task automatic port_b(bit en, bit req, bit rnw, logic sel);
        bit q;
        logic [35:0] exp;
        @(negedge clk_b);
        en_b = en; req_b = req; rnw_b = rnw; sel_b = sel;
        q = en && req && rnw && sel;
        @(posedge clk_b); #1;
        en_b = 0; req_b = 0;
        if (q && model_q.size() > 0) begin
            exp = model_q.pop_front();
            last_rd = exp;
            if (!oe_b_n) check(dout_b === exp, "R3", "read word order", dout_b, exp);
            if (model_q.size() == 0) check(empty_b === 1'b1, "R6", "empty at emptying edge", empty_b, 1);
        end else if (!oe_b_n) begin
            check(dout_b === last_rd, q ? "R4" : "R3", "output held", dout_b, last_rd);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk_a);
        repeat (5) @(posedge clk_b);
        @(negedge clk_a); #1;
    endtask

    task automatic check_flags(int cnt, string tag);
        check(full_a === (cnt == DEPTH), "R5", {tag, " full"}, full_a, cnt == DEPTH);
        check(empty_b === (cnt == 0), "R6", {tag, " empty"}, empty_b, cnt == 0);
        check(half_a === (cnt > DEPTH / 2), "R7", {tag, " half"}, half_a, cnt > DEPTH / 2);
    endtask

    task automatic do_reset();
        mon_on = 0;
        rst_a = 1; rst_b = 1;
        repeat (3) @(posedge clk_a);
        repeat (3) @(posedge clk_b);
        @(negedge clk_a); rst_a = 0;
        @(negedge clk_b); rst_b = 0;
        model_q.delete();
        last_rd = '0;
        #1 mon_on = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk_a);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [35:0] w;
        do_reset();
        // R9: reset state
        check(empty_b === 1'b1, "R9", "empty after reset", empty_b, 1);
        check(full_a === 1'b0, "R9", "full after reset", full_a, 0);
        check(half_a === 1'b0, "R9", "half after reset", half_a, 0);
        check(dout_b === '0, "R9", "dout after reset", dout_b, 0);

        // R1: each missing qualifier blocks the write
        port_a(0, 1, 0, 3'd4, 36'h1);
        port_a(1, 0, 0, 3'd4, 36'h2);
        port_a(1, 1, 1, 3'd4, 36'h3);
        port_a(1, 1, 0, 3'd2, 36'h4);
        settle();
        check(empty_b === 1'b1, "R1", "unqualified writes stored nothing", empty_b, 1);
        port_a(1, 1, 0, 3'd4, next_word());
        settle();
        check(empty_b === 1'b0, "R1", "qualified write stored", empty_b, 0);

        // R3: each missing qualifier blocks the read
        port_b(0, 1, 1, 1);
        port_b(1, 0, 1, 1);
        port_b(1, 1, 0, 1);
        port_b(1, 1, 1, 0);
        port_b(1, 1, 1, 1);
        settle();
        check_flags(0, "after single word");

        // table of batches
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < VEC[v][0]; i++) port_a(1, 1, 0, 3'd4, next_word());
            for (int i = 0; i < VEC[v][1]; i++) port_b(1, 1, 1, 1);
            settle();
            check(model_q.size() == VEC[v][2], "R2", "model occupancy", 36'(model_q.size()), 36'(VEC[v][2]));
            check_flags(VEC[v][2], "table");
        end

        // R8: output enable gates data but not the read
        w = next_word();
        port_a(1, 1, 0, 3'd4, w);
        settle();
        oe_b_n = 1;
        port_b(1, 1, 1, 1);
        check(dout_b === '0, "R8", "disabled output zero", dout_b, 0);
        settle();
        check(empty_b === 1'b1, "R8", "read while disabled popped", empty_b, 1);
        oe_b_n = 0; #1;
        check(dout_b === w, "R8", "held word after enable", dout_b, w);

        // concurrent stream, R3 order across domains
        fork
            begin
                int sent = 0;
                while (sent < 60) begin
                    bit go;
                    @(negedge clk_a); #1;
                    go = !full_a;
                    w = next_word();
                    if (go) begin en_a = 1; req_a = 1; rnw_a = 0; sel_a = 3'd4; din_a = w; end
                    @(posedge clk_a); #1;
                    en_a = 0;
                    if (go) begin model_q.push_back(w); sent++; end
                end
            end
            begin
                int got = 0;
                while (got < 60) begin
                    bit go;
                    logic [35:0] e;
                    @(negedge clk_b); #1;
                    go = !empty_b;
                    if (go) begin en_b = 1; req_b = 1; rnw_b = 1; sel_b = 1; end
                    @(posedge clk_b); #1;
                    en_b = 0;
                    if (go) begin
                        e = model_q.pop_front();
                        check(dout_b === e, "R3", "stream order", dout_b, e);
                        got++;
                    end
                end
            end
        join
        settle();
        check_flags(0, "after stream");

        // R9: reset with data inside
        for (int i = 0; i < 10; i++) port_a(1, 1, 0, 3'd4, next_word());
        settle();
        do_reset();
        check(empty_b === 1'b1, "R9", "empty after mid reset", empty_b, 1);
        check(half_a === 1'b0, "R9", "half after mid reset", half_a, 0);
        check(dout_b === '0, "R9", "dout after mid reset", dout_b, 0);
        settle();
        check(empty_b === 1'b1, "R9", "still empty after settle", empty_b, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule